// File: doc/BRIEF.md
# Fixed-Point Gauss-Jordan Matrix Inverter

This block computes the inverse of a small square matrix held in two internal register banks. The working bank holds the source matrix, which is written one element at a time through a load port while the block is idle. The result bank is set to the identity when a run starts. Every row operation the block applies to the working bank is also applied to the result bank. When the run ends, the result bank holds the inverse, and a separate read port returns it one element at a time.

The forward sweep takes each pivot column in turn. It first divides the pivot row by its own diagonal entry. It then takes each lower row, divides it by that row's own entry in the pivot column, and subtracts the pivot row from it. At the end of this sweep the working bank is upper triangular with a unit diagonal. The backward sweep then clears the terms above the diagonal. It does this by subtracting a scaled lower row from each upper row, and it changes only the result bank. All arithmetic is signed two's-complement Q16.16, meaning the stored value equals the real value times 65536. Division uses a bit-serial restoring divider and multiplication uses a single product unit.

The sequencer has these states. `ST_IDLE` leaves on `start` to `ST_FPIV_RD`. `ST_FPIV_RD` leads to `ST_FPIV_LAT`, which goes to `ST_IDLE` when the factor is zero and to `ST_FEL_RD` otherwise. The element loop runs `ST_FEL_RD` → `ST_FEL_DIV` → `ST_FEL_WAIT`, then to `ST_FEL_WR` when the divider finishes. `ST_FEL_WR` goes back to `ST_FEL_RD` for the other bank or the next column, to `ST_FPIV_RD` for the next row or pivot, or to `ST_BPIV_RD` after the last element of the forward sweep. The backward sweep runs `ST_BPIV_RD` → `ST_BPIV_LAT` → `ST_BEL_RD` → `ST_BEL_OTH` → `ST_BEL_WR`. `ST_BEL_WR` goes back to `ST_BEL_RD` for the next column, to `ST_BPIV_RD` for the next row or pivot, or to `ST_IDLE` when the run is finished.

Top module: `gj_inverter`

## Requirements
- R1: While `busy` is low, a cycle with `ld_we` high writes `ld_data` into the working bank at zero-based row `ld_row` and column `ld_col`. While `busy` is high, `ld_we` has no effect on the working bank or on the result.
- R2: When `start` is high in a cycle where `busy` is low, the next cycle shows `busy` high with `done` and `err` low, and the result bank is reset to the identity (1.0 = 0x00010000 on the diagonal, 0 elsewhere).
- R3: For each pivot k, the factor f is the element at (k,k) of the working bank, read before the row changes. Every element x of row k in both banks becomes x/f. The quotient is formed as (|x|·65536)/|f|, truncated toward zero, kept in its low 32 bits, and negated when the signs of x and f differ.
- R4: For each row r below pivot k, f is the element at (r,k) of the working bank, read before row r changes. Every element of row r in both banks becomes its quotient by f, formed as in R3, minus the matching element of the already-normalised row k, with wrap-around on 32 bits.
- R5: The backward sweep runs k from n−1 down to 1, and for each k runs r from k−1 down to 0. Each result-bank element (r,c) becomes itself minus (f·B(k,c)) shifted right arithmetically by 16, wrapping on 32 bits, where f is working element (r,k). The working bank is not written in this sweep.
- R6: If any forward factor f is zero, the run stops with `err` and `done` both high. The result bank then holds exactly the row operations completed before that factor was read.
- R7: While `busy` is low, `rd_data` equals the result-bank element at the (`rd_row`,`rd_col`) presented one cycle earlier.
- R8: `done` and `busy` are never high together. `done` rises in the same cycle that `busy` falls, and it stays high until the next accepted `start`.
- R9: After reset, `busy`, `done` and `err` are low, the working bank is all zeros and the result bank is the identity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Write strobe for the working bank |
| ld_row | input | $clog2(N) | Row index for the write |
| ld_col | input | $clog2(N) | Column index for the write |
| ld_data | input | W | Q16.16 element to write |
| start | input | 1 | Starts an inversion when idle |
| rd_row | input | $clog2(N) | Row index for reading the result bank |
| rd_col | input | $clog2(N) | Column index for reading the result bank |
| rd_data | output | W | Result-bank element, one cycle after its address |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | Run finished; held until the next start |
| err | output | 1 | Run stopped on a zero factor |

## Verification
Most faults in the loop indices, factor latch, divider or update arithmetic never appear on the flags. They surface only as wrong result elements once `busy` falls, and the full sweep of the result bank after each run exposes them within n² cycles. A wrong pivot order or a missed zero-factor check shows up differently: `err` takes the wrong value at the end of the run, or `busy` falls in a different cycle with a partly transformed result bank. Matrices whose lower triangle produces a zero factor in the first column, in a later column, or not at all, separate these cases.

// File: rtl/gj_pkg.sv
`timescale 1ns/1ps
package gj_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_FPIV_RD,
        ST_FPIV_LAT,
        ST_FEL_RD,
        ST_FEL_DIV,
        ST_FEL_WAIT,
        ST_FEL_WR,
        ST_BPIV_RD,
        ST_BPIV_LAT,
        ST_BEL_RD,
        ST_BEL_OTH,
        ST_BEL_WR
    } gj_state_e;
endpackage

// File: rtl/gj_bank.sv
`timescale 1ns/1ps
// Square bank of elements with one write port and one registered read port.
module gj_bank #(
    parameter int W     = 32,
    parameter int FRAC  = 16,
    parameter int IW    = 2,
    parameter bit IDENT = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          we,
    input  logic [IW-1:0] wr_row,
    input  logic [IW-1:0] wr_col,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [W-1:0]  rd_data
);
    localparam int NP = 1 << IW;
    localparam logic [W-1:0] ONE = W'(1) << FRAC;

    logic [W-1:0] mem [NP][NP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NP; r++)
                for (int c = 0; c < NP; c++)
                    mem[r][c] <= (IDENT && r == c) ? ONE : '0;
            rd_data <= '0;
        end else begin
            if (init) begin
                for (int r = 0; r < NP; r++)
                    for (int c = 0; c < NP; c++)
                        mem[r][c] <= (r == c) ? ONE : '0;
            end else if (we) begin
                mem[wr_row][wr_col] <= wr_data;
            end
            rd_data <= mem[rd_row][rd_col];
        end
    end
endmodule

// File: rtl/gj_divider.sv
`timescale 1ns/1ps
// Signed fixed-point restoring divider, one quotient bit per cycle.
module gj_divider #(
    parameter int W    = 32,
    parameter int FRAC = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo,
    output logic         done
);
    localparam int DW = W + FRAC;
    localparam int CW = $clog2(DW);

    logic          run, neg;
    logic [CW-1:0] cnt;
    logic [DW-1:0] dvd;
    logic [W-1:0]  rem, dmag, nmag;
    logic [W:0]    rem_sh;

    assign nmag   = num[W-1] ? -num : num;
    assign rem_sh = {rem, dvd[DW-1]};
    assign quo    = neg ? -dvd[W-1:0] : dvd[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0; done <= 1'b0; neg <= 1'b0;
            cnt <= '0; dvd <= '0; rem <= '0; dmag <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run  <= 1'b1;
                cnt  <= '0;
                rem  <= '0;
                dvd  <= {nmag, {FRAC{1'b0}}};
                dmag <= den[W-1] ? -den : den;
                neg  <= num[W-1] ^ den[W-1];
            end else if (run) begin
                cnt <= cnt + 1'b1;
                if (rem_sh >= {1'b0, dmag}) begin
                    rem <= W'(rem_sh - {1'b0, dmag});
                    dvd <= {dvd[DW-2:0], 1'b1};
                end else begin
                    rem <= rem_sh[W-1:0];
                    dvd <= {dvd[DW-2:0], 1'b0};
                end
                if (cnt == CW'(DW - 1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // R3: a finished quotient only follows a running division
    a_r3_done_after_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(run));
    // R3: a new division is never launched over one in flight
    a_r3_go_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !run);
endmodule

// File: rtl/gj_inverter.sv
`timescale 1ns/1ps
module gj_inverter
    import gj_pkg::*;
#(
    parameter int N    = 4,
    parameter int W    = 32,
    parameter int FRAC = 16,
    localparam int IW  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [IW-1:0] ld_row,
    input  logic [IW-1:0] ld_col,
    input  logic [W-1:0]  ld_data,
    input  logic          start,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [W-1:0]  rd_data,
    output logic          busy,
    output logic          done,
    output logic          err
);
    localparam logic [IW-1:0] LAST = IW'(N - 1);

    gj_state_e     st, st_d;
    logic [IW-1:0] i_q, i_d, r_q, r_d, c_q, c_d;
    logic          bsel_q, bsel_d;
    logic [W-1:0]  f_q, x_q;
    logic          done_q, err_q;

    logic          a_we, b_we, b_init, div_go, div_done;
    logic [IW-1:0] a_rr, a_rc, b_rr, b_rc, a_wr, a_wc;
    logic [W-1:0]  a_rd, b_rd, quo, sel_rd, el_res, back_res, a_wd, b_wd;

    function automatic logic [W-1:0] qmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = $signed({{W{a[W-1]}}, a}) * $signed({{W{b[W-1]}}, b});
        return W'(p >>> FRAC);
    endfunction

    assign busy     = (st != ST_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign rd_data  = b_rd;
    assign sel_rd   = bsel_q ? b_rd : a_rd;
    assign el_res   = (r_q == i_q) ? quo : quo - sel_rd;
    assign back_res = x_q - qmul(f_q, b_rd);
    assign a_wr     = busy ? r_q : ld_row;
    assign a_wc     = busy ? c_q : ld_col;
    assign a_wd     = busy ? el_res : ld_data;
    assign b_wd     = (st == ST_BEL_WR) ? back_res : el_res;

    gj_bank #(.W(W), .FRAC(FRAC), .IW(IW), .IDENT(1'b0)) u_abank (
        .clk, .rst_n, .init(1'b0), .we(a_we), .wr_row(a_wr), .wr_col(a_wc),
        .wr_data(a_wd), .rd_row(a_rr), .rd_col(a_rc), .rd_data(a_rd));

    gj_bank #(.W(W), .FRAC(FRAC), .IW(IW), .IDENT(1'b1)) u_bbank (
        .clk, .rst_n, .init(b_init), .we(b_we), .wr_row(r_q), .wr_col(c_q),
        .wr_data(b_wd), .rd_row(b_rr), .rd_col(b_rc), .rd_data(b_rd));

    gj_divider #(.W(W), .FRAC(FRAC)) u_div (
        .clk, .rst_n, .go(div_go), .num(sel_rd), .den(f_q), .quo, .done(div_done));

    // next state and loop indices
    always_comb begin
        st_d = st; i_d = i_q; r_d = r_q; c_d = c_q; bsel_d = bsel_q;
        unique case (st)
            ST_IDLE:     if (start) begin st_d = ST_FPIV_RD; i_d = '0; r_d = '0; end
            ST_FPIV_RD:  st_d = ST_FPIV_LAT;
            ST_FPIV_LAT: if (a_rd == '0) st_d = ST_IDLE;
                         else begin st_d = ST_FEL_RD; c_d = '0; bsel_d = 1'b0; end
            ST_FEL_RD:   st_d = ST_FEL_DIV;
            ST_FEL_DIV:  st_d = ST_FEL_WAIT;
            ST_FEL_WAIT: if (div_done) st_d = ST_FEL_WR;
            ST_FEL_WR: begin
                if (!bsel_q) begin
                    bsel_d = 1'b1; st_d = ST_FEL_RD;
                end else begin
                    bsel_d = 1'b0;
                    if (c_q != LAST) begin c_d = c_q + 1'b1; st_d = ST_FEL_RD; end
                    else if (r_q != LAST) begin r_d = r_q + 1'b1; st_d = ST_FPIV_RD; end
                    else if (i_q != LAST) begin
                        i_d = i_q + 1'b1; r_d = i_q + 1'b1; st_d = ST_FPIV_RD;
                    end else begin
                        i_d = LAST; r_d = LAST - IW'(1); st_d = ST_BPIV_RD;
                    end
                end
            end
            ST_BPIV_RD:  st_d = ST_BPIV_LAT;
            ST_BPIV_LAT: begin c_d = '0; st_d = ST_BEL_RD; end
            ST_BEL_RD:   st_d = ST_BEL_OTH;
            ST_BEL_OTH:  st_d = ST_BEL_WR;
            ST_BEL_WR: begin
                if (c_q != LAST) begin c_d = c_q + 1'b1; st_d = ST_BEL_RD; end
                else if (r_q != '0) begin r_d = r_q - IW'(1); st_d = ST_BPIV_RD; end
                else if (i_q != IW'(1)) begin
                    i_d = i_q - IW'(1); r_d = i_q - IW'(2); st_d = ST_BPIV_RD;
                end else st_d = ST_IDLE;
            end
            default:     st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_d;
    end

    // indices, factor, captured operand, flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            i_q <= '0; r_q <= '0; c_q <= '0; bsel_q <= 1'b0;
            f_q <= '0; x_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
        end else begin
            i_q <= i_d; r_q <= r_d; c_q <= c_d; bsel_q <= bsel_d;
            if (st == ST_IDLE && start) begin done_q <= 1'b0; err_q <= 1'b0; end
            if (st == ST_FPIV_LAT || st == ST_BPIV_LAT) f_q <= a_rd;
            if (st == ST_FPIV_LAT && a_rd == '0) begin err_q <= 1'b1; done_q <= 1'b1; end
            if (st == ST_BEL_OTH) x_q <= b_rd;
            if (st == ST_BEL_WR && st_d == ST_IDLE) done_q <= 1'b1;
        end
    end

    // bank addressing, write enables, divider launch
    always_comb begin
        a_rr = r_q; a_rc = c_q; b_rr = r_q; b_rc = c_q;
        a_we = 1'b0; b_we = 1'b0; b_init = 1'b0; div_go = 1'b0;
        unique case (st)
            ST_IDLE: begin
                b_rr = rd_row; b_rc = rd_col; a_we = ld_we; b_init = start;
            end
            ST_FPIV_RD, ST_BPIV_RD: a_rc = i_q;
            ST_FEL_DIV, ST_FEL_WAIT: begin
                div_go = (st == ST_FEL_DIV); a_rr = i_q; b_rr = i_q;
            end
            ST_FEL_WR: begin
                a_rr = i_q; b_rr = i_q; a_we = !bsel_q; b_we = bsel_q;
            end
            ST_BEL_OTH, ST_BEL_WR: begin
                b_rr = i_q; b_we = (st == ST_BEL_WR);
            end
            default: ;
        endcase
    end

    // R8: completion and activity never overlap
    a_r8_done_excl_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && busy));
    // R2: accepted start gives busy with flags cleared on the next cycle
    a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done_q && !err_q));
    // R6: an error is always reported together with completion
    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> done_q);
    // R5: the working bank is frozen throughout the backward sweep
    a_r5_a_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st inside {ST_BPIV_RD, ST_BPIV_LAT, ST_BEL_RD, ST_BEL_OTH, ST_BEL_WR}) |-> !a_we);
    // R1: external loads reach the working bank only while idle
    a_r1_load_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ld_we && !$past(busy)) |-> !(a_we && a_wd == ld_data && st == ST_FPIV_RD));
endmodule

// File: tb/gj_inverter_test.sv
`timescale 1ns/1ps
module gj_inverter_test;
    localparam int N  = 4;
    localparam int W  = 32;
    localparam int IW = $clog2(N);
    localparam logic [31:0] ONE = 32'h0001_0000;

    logic clk = 1'b0, rst_n = 1'b0, ld_we = 1'b0, start = 1'b0;
    logic [IW-1:0] ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
    logic [W-1:0]  ld_data = '0;
    logic [W-1:0]  rd_data;
    logic busy, done, err;

    gj_inverter #(.N(N), .W(W), .FRAC(16)) uut (
        .clk, .rst_n, .ld_we, .ld_row, .ld_col, .ld_data, .start,
        .rd_row, .rd_col, .rd_data, .busy, .done, .err);

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [31:0] m_a [N][N], m_b [N][N], e_a [N][N], e_b [N][N], tm [N][N];
    bit m_run = 0, m_done = 0, m_err = 0, e_err = 0, first_run = 0, pend = 0, finished = 0;
    logic [IW-1:0] pr = '0, pc = '0;
    string cur_tag = "R9 reset";

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mdiv(input logic [31:0] a, input logic [31:0] f);
        longint ua, uf, q;
        logic [31:0] t;
        ua = a[31] ? -longint'($signed(a)) : longint'($signed(a));
        uf = f[31] ? -longint'($signed(f)) : longint'($signed(f));
        q  = (ua <<< 16) / uf;
        t  = q[31:0];
        return (a[31] ^ f[31]) ? -t : t;
    endfunction

    function automatic logic [31:0] mmul(input logic [31:0] a, input logic [31:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[47:16];
    endfunction

    // behavioural reference of one whole run (R3, R4, R5, R6)
    task automatic model_run();
        logic [31:0] f;
        e_a = m_a;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) e_b[r][c] = (r == c) ? ONE : 32'h0;
        e_err = 0;
        for (int i = 0; i < N; i++) begin
            for (int r = i; r < N; r++) begin
                f = e_a[r][i];
                if (f == 32'h0) begin e_err = 1; return; end
                for (int c = 0; c < N; c++) begin
                    if (r == i) begin
                        e_a[r][c] = mdiv(e_a[r][c], f);
                        e_b[r][c] = mdiv(e_b[r][c], f);
                    end else begin
                        e_a[r][c] = mdiv(e_a[r][c], f) - e_a[i][c];
                        e_b[r][c] = mdiv(e_b[r][c], f) - e_b[i][c];
                    end
                end
            end
        end
        for (int i = N - 1; i > 0; i--)
            for (int r = i - 1; r >= 0; r--) begin
                f = e_a[r][i];
                for (int c = 0; c < N; c++) e_b[r][c] = e_b[r][c] - mmul(f, e_b[i][c]);
            end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (m_run) begin
                if (first_run) begin
                    chk(busy && !done && !err, "R2 busy with flags clear after start",
                        32'({busy, done, err}), 32'(3'b100));
                    first_run = 0;
                end else if (busy) begin
                    chk(!done, "R8 done low while busy", 32'(done), 32'h0);
                end else begin
                    chk(done, "R8 done when busy falls", 32'(done), 32'h1);
                    chk(err == e_err, "R6 error flag at end of run", 32'(err), 32'(e_err));
                    m_run = 0; m_a = e_a; m_b = e_b; m_done = 1; m_err = e_err;
                end
            end else begin
                chk(!busy && done == m_done && err == m_err, {cur_tag, " / R8 idle flags"},
                    32'({busy, done, err}), 32'({1'b0, m_done, m_err}));
                if (pend)
                    chk(rd_data == m_b[pr][pc], {cur_tag, " / R7 result element"},
                        rd_data, m_b[pr][pc]);
            end
            pend = !busy && !m_run;
            pr = rd_row; pc = rd_col;
            if (!busy && ld_we) m_a[ld_row][ld_col] = ld_data;
            if (!busy && start) begin
                model_run();
                m_run = 1; first_run = 1; m_done = 0; m_err = 0;
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic load_tm();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ld_we = 1'b1; ld_row = IW'(r); ld_col = IW'(c); ld_data = tm[r][c];
                tick();
            end
        ld_we = 1'b0;
        tick();
    endtask

    task automatic run_it(input bit disturb);
        int k;
        k = 0;
        start = 1'b1;
        tick();
        start = 1'b0;
        while (busy) begin
            if (disturb) begin
                ld_we = 1'b1; ld_row = IW'(k); ld_col = IW'(k + 1);
                ld_data = 32'hDEAD_0000 + 32'(k);
                k++;
            end
            tick();
        end
        ld_we = 1'b0;
        tick();
    endtask

    task automatic read_all(input string tag);
        cur_tag = tag;
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                rd_row = IW'(r); rd_col = IW'(c);
                tick();
            end
        tick();
    endtask

    task automatic set_dense();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                tm[r][c] = (r == c) ? 32'((N + 2) * 65536) : 32'((r + c + 1) * 32768);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                m_a[r][c] = 32'h0;
                m_b[r][c] = (r == c) ? ONE : 32'h0;
            end
        #12 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R9 flags after reset", 32'({busy, done, err}), 32'h0);
        tick();
        read_all("R9 identity after reset");

        // dense positive matrix: forward and backward sweeps
        set_dense();
        load_tm();
        run_it(0);
        read_all("R3 R4 R5 dense positive");

        // mixed signs and fractional entries
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                int v;
                v = (r == c) ? -5 * 65536 : (((r + c) % 2) ? -1 : 1) * (r + 2 * c + 1) * 16384;
                tm[r][c] = 32'(v);
            end
        load_tm();
        run_it(0);
        read_all("R3 R4 R5 mixed signs");

        // zero at the first pivot: immediate stop, result bank stays identity
        set_dense();
        tm[0][0] = 32'h0;
        load_tm();
        run_it(0);
        read_all("R6 zero first pivot");

        // restart after an error clears the flags, then identical rows stop at pivot 1
        set_dense();
        for (int c = 0; c < N; c++) tm[1][c] = tm[0][c];
        load_tm();
        run_it(0);
        read_all("R6 repeated rows partial result");

        // diagonal matrix: zero below the first pivot stops the run
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) tm[r][c] = (r == c) ? 32'((r + 2) * 65536) : 32'h0;
        load_tm();
        run_it(0);
        read_all("R6 R4 zero lower factor");

        // loads during a run are ignored
        set_dense();
        load_tm();
        run_it(1);
        read_all("R1 loads ignored while busy");

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete actual=busy expected=idle");
            summary();
            $finish;
        end
    end
endmodule